// File: doc/BRIEF.md
# Slot-Table Round-Robin Thread Selector

This block decides, every clock, which hardware thread owns the next issue slot of a shared pipeline. A circular table of programmable length holds one thread number per entry. A pointer walks through the table one entry per clock and returns to entry 0 after the last active entry. A thread therefore gets a fixed share of issue cycles, set by how many entries carry its number. A thread may appear in several entries that are not next to each other, which spreads its cycles evenly over the rotation.

When the thread named by the current entry cannot run, the cycle is not wasted. It is offered to a designated spare thread, such as a background or debug task, provided that thread can run. When neither can run, the slot is left empty. The table is loaded through a simple write port. The active length and the spare thread number are plain inputs that the surrounding logic holds steady.

The grant is a registered decision driven by a small state machine. Its states are ST_IDLE (the state after reset, no grant), ST_OWNER (the table entry's thread was granted), ST_SPARE (the spare thread was granted) and ST_STALL (no thread could run). On every clock edge after reset, the machine moves from any state to one of the three decision states. It goes to ST_OWNER when the entry's thread is ready. Otherwise it goes to ST_SPARE when the spare thread is ready. Otherwise it goes to ST_STALL. Reset is the only way back to ST_IDLE.

Top module: `thread_slot_sched`

## Requirements
- R1: While reset is held and in the cycle after it is released, grant_valid_o is 0 and grant_tid_o is 0. The pointer starts at entry 0 and every table entry holds thread 0, so with length 1 and thread 0 ready the first grant is thread 0.
- R2: The pointer advances by one entry on each clock edge. On the edge where (pointer + 1) is at or above len_i, it returns to entry 0 instead. A length of 0 or 1 therefore holds it at entry 0.
- R3: The wrap point follows the length currently driven. If len_i is lowered to a value at or below the current entry, the pointer returns to entry 0 on the next edge.
- R4: If the thread in the current entry has its ready_i bit set, then after the next edge grant_valid_o is 1 and grant_tid_o is that thread.
- R5: If the entry's thread is not ready but the thread on fb_tid_i is, then after the next edge grant_valid_o is 1 and grant_tid_o equals fb_tid_i.
- R6: If neither the entry's thread nor the spare thread is ready, then after the next edge grant_valid_o is 0 and grant_tid_o is 0.
- R7: With every thread ready, over one full rotation each thread is granted as many cycles as the number of entries that hold its number. In the table 1,2,1,3,1,2,1,4,1,5 with length 10, that is 5 grants for thread 1, 2 for thread 2 and 1 each for threads 3, 4 and 5.
- R8: A write with wr_en_i high replaces entry wr_addr_i on the next edge. A decision taken on the same edge from that same entry still uses the old thread number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Table write strobe |
| wr_addr_i | input | ADDR_W (4) | Table entry to write |
| wr_tid_i | input | TID_W (3) | Thread number to store |
| len_i | input | LEN_W (5) | Number of active table entries |
| ready_i | input | NUM_THREADS (8) | Per-thread computable flags, bit n for thread n |
| fb_tid_i | input | TID_W (3) | Spare thread that takes slots the owner cannot use |
| grant_valid_o | output | 1 | A thread owns this pipeline slot |
| grant_tid_o | output | TID_W (3) | Granted thread number, 0 when no grant |

## Verification
Each decision is based on the pointer, the table entry, ready_i and fb_tid_i during one cycle. It appears on grant_valid_o and grant_tid_o one clock edge later and stays there until the following edge. Table writes and length changes are registered on the same edge, so they affect the decision one cycle later. The bench changes inputs on falling edges and reads the grant on the next falling edge, exactly one rising edge later. It tracks the pointer by counting rising edges from a point where length 0 has forced it to entry 0.

// File: rtl/sched_pkg.sv
package sched_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OWNER = 2'd1,
        ST_SPARE = 2'd2,
        ST_STALL = 2'd3
    } grant_state_e;

endpackage

// File: rtl/slot_table.sv
module slot_table #(
    parameter int DEPTH  = 16,
    parameter int TID_W  = 3,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [TID_W-1:0]  wr_tid_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [TID_W-1:0]  rd_tid_o
);

    logic [TID_W-1:0] entry_q [DEPTH];

    // One register per entry with its own write decode.
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entry_q[e] <= '0;
            end else if (wr_en_i && (wr_addr_i == ADDR_W'(e))) begin
                entry_q[e] <= wr_tid_i;
            end
        end
    end

    // The read sees the content from before any write on this edge.
    always_comb begin
        rd_tid_o = entry_q[rd_addr_i];
    end

endmodule

// File: rtl/slot_pointer.sv
module slot_pointer #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 4,
    parameter int LEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  len_i,
    output logic [ADDR_W-1:0] ptr_o
);

    localparam logic [LEN_W-1:0] LAST_LIMIT = LEN_W'(DEPTH);

    logic [ADDR_W-1:0] ptr_q;
    logic [LEN_W-1:0]  step_w;
    logic              wrap_w;

    always_comb begin
        step_w = LEN_W'(ptr_q) + LEN_W'(1);
        // Wrap at the driven length, and never run off the table.
        wrap_w = (step_w >= len_i) || (step_w >= LAST_LIMIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (wrap_w) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_q + ADDR_W'(1);
        end
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/grant_fsm.sv
module grant_fsm
    import sched_pkg::*;
#(
    parameter int NUM_THREADS = 8,
    parameter int TID_W       = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [TID_W-1:0]       slot_tid_i,
    input  logic [NUM_THREADS-1:0] ready_i,
    input  logic [TID_W-1:0]       fb_tid_i,
    output logic                   grant_valid_o,
    output logic [TID_W-1:0]       grant_tid_o
);

    grant_state_e     state_q, state_d;
    logic [TID_W-1:0] tid_q, tid_d;
    logic             owner_rdy, spare_rdy;

    always_comb begin
        owner_rdy = ready_i[slot_tid_i];
        spare_rdy = ready_i[fb_tid_i];
        if (owner_rdy) begin
            state_d = ST_OWNER;
            tid_d   = slot_tid_i;
        end else if (spare_rdy) begin
            state_d = ST_SPARE;
            tid_d   = fb_tid_i;
        end else begin
            state_d = ST_STALL;
            tid_d   = '0;
        end
    end

    // State register: every state leaves on each edge to a decision state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tid_q   <= '0;
        end else begin
            state_q <= state_d;
            tid_q   <= tid_d;
        end
    end

    // Output decode.
    always_comb begin
        unique case (state_q)
            ST_OWNER, ST_SPARE: begin
                grant_valid_o = 1'b1;
                grant_tid_o   = tid_q;
            end
            ST_IDLE, ST_STALL: begin
                grant_valid_o = 1'b0;
                grant_tid_o   = '0;
            end
            default: begin
                grant_valid_o = 1'b0;
                grant_tid_o   = '0;
            end
        endcase
    end

endmodule

// File: rtl/thread_slot_sched.sv
module thread_slot_sched #(
    parameter int NUM_THREADS = 8,
    parameter int DEPTH       = 16,
    parameter int TID_W       = $clog2(NUM_THREADS),
    parameter int ADDR_W      = $clog2(DEPTH),
    parameter int LEN_W       = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [ADDR_W-1:0]      wr_addr_i,
    input  logic [TID_W-1:0]       wr_tid_i,
    input  logic [LEN_W-1:0]       len_i,
    input  logic [NUM_THREADS-1:0] ready_i,
    input  logic [TID_W-1:0]       fb_tid_i,
    output logic                   grant_valid_o,
    output logic [TID_W-1:0]       grant_tid_o
);

    logic [ADDR_W-1:0] ptr_q;
    logic [TID_W-1:0]  slot_tid;

    slot_pointer #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .len_i (len_i),
        .ptr_o (ptr_q)
    );

    slot_table #(
        .DEPTH  (DEPTH),
        .TID_W  (TID_W),
        .ADDR_W (ADDR_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_tid_i  (wr_tid_i),
        .rd_addr_i (ptr_q),
        .rd_tid_o  (slot_tid)
    );

    grant_fsm #(
        .NUM_THREADS (NUM_THREADS),
        .TID_W       (TID_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .slot_tid_i    (slot_tid),
        .ready_i       (ready_i),
        .fb_tid_i      (fb_tid_i),
        .grant_valid_o (grant_valid_o),
        .grant_tid_o   (grant_tid_o)
    );

endmodule

// File: rtl/thread_slot_sched_chk.sv
module thread_slot_sched_chk #(
    parameter int NUM_THREADS = 8,
    parameter int TID_W       = 3,
    parameter int ADDR_W      = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_THREADS-1:0] ready_i,
    input logic [TID_W-1:0]       fb_tid_i,
    input logic [TID_W-1:0]       slot_tid,
    input logic [ADDR_W-1:0]      ptr_q,
    input logic                   grant_valid_o,
    input logic [TID_W-1:0]       grant_tid_o
);

    logic             started_q;
    logic             owner_rdy_q, spare_rdy_q;
    logic [TID_W-1:0] slot_q, fb_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started_q   <= 1'b0;
            owner_rdy_q <= 1'b0;
            spare_rdy_q <= 1'b0;
            slot_q      <= '0;
            fb_q        <= '0;
        end else begin
            started_q   <= 1'b1;
            owner_rdy_q <= ready_i[slot_tid];
            spare_rdy_q <= ready_i[fb_tid_i];
            slot_q      <= slot_tid;
            fb_q        <= fb_tid_i;
        end
    end

    assert_owner_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && owner_rdy_q) |-> (grant_valid_o && grant_tid_o == slot_q));

    assert_spare_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && !owner_rdy_q && spare_rdy_q) |-> (grant_valid_o && grant_tid_o == fb_q));

    assert_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && !grant_valid_o) |-> (!owner_rdy_q && !spare_rdy_q && grant_tid_o == '0));

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !started_q |-> (!grant_valid_o && ptr_q == '0));

    assert_pointer_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && ptr_q != '0) |-> (ptr_q == $past(ptr_q) + ADDR_W'(1)));

endmodule

bind thread_slot_sched thread_slot_sched_chk #(
    .NUM_THREADS (NUM_THREADS),
    .TID_W       (TID_W),
    .ADDR_W      (ADDR_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ready_i       (ready_i),
    .fb_tid_i      (fb_tid_i),
    .slot_tid      (slot_tid),
    .ptr_q         (ptr_q),
    .grant_valid_o (grant_valid_o),
    .grant_tid_o   (grant_tid_o)
);

// File: tb/test_thread_slot_sched.sv
module test_thread_slot_sched;

    localparam int NT = 8;
    localparam int TW = 3;
    localparam int AW = 4;
    localparam int LW = 5;
    localparam int NVEC = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [TW-1:0] wr_tid = '0;
    logic [LW-1:0] len = '0;
    logic [NT-1:0] ready = '0;
    logic [TW-1:0] fb = '0;
    logic          gvalid;
    logic [TW-1:0] gtid;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    thread_slot_sched i_thread_slot_sched (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (wr_en),
        .wr_addr_i     (wr_addr),
        .wr_tid_i      (wr_tid),
        .len_i         (len),
        .ready_i       (ready),
        .fb_tid_i      (fb),
        .grant_valid_o (gvalid),
        .grant_tid_o   (gtid)
    );

    // Table contents programmed before the vector walk.
    localparam logic [TW-1:0] PROG [10] = '{3'd1, 3'd2, 3'd1, 3'd3, 3'd1,
                                          3'd2, 3'd1, 3'd4, 3'd1, 3'd5};

    // {ready[15:8], fallback[7:5], exp_valid[4], pad[3], exp_tid[2:0]}
    // Vector i is decided at pointer entry (i mod 10).
    localparam logic [15:0] VEC [NVEC] = '{
        {8'hFF,       3'd0, 1'b1, 1'b0, 3'd1},  // R4 entry 0
        {8'hFF,       3'd0, 1'b1, 1'b0, 3'd2},  // R4 entry 1
        {8'b11111101, 3'd7, 1'b1, 1'b0, 3'd7},  // R5 thread 1 blocked
        {8'b00000000, 3'd6, 1'b0, 1'b0, 3'd0},  // R6 nobody ready
        {8'b00000010, 3'd0, 1'b1, 1'b0, 3'd1},  // R4 only owner ready
        {8'b00000001, 3'd0, 1'b1, 1'b0, 3'd0},  // R5 spare thread 0
        {8'hFF,       3'd0, 1'b1, 1'b0, 3'd1},  // R4
        {8'b11101111, 3'd5, 1'b1, 1'b0, 3'd5},  // R5 thread 4 blocked
        {8'hFF,       3'd0, 1'b1, 1'b0, 3'd1},  // R4
        {8'hFF,       3'd0, 1'b1, 1'b0, 3'd5},  // R4 last entry
        {8'hFF,       3'd0, 1'b1, 1'b0, 3'd1},  // R2 wrap to entry 0
        {8'b00000100, 3'd3, 1'b1, 1'b0, 3'd2}   // R4 owner beats spare
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            finish_run();
        end
    end

    initial begin
        int cnt [NT];
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 valid in reset", int'(gvalid), 0);
        check("R1 tid in reset", int'(gtid), 0);
        rst_n = 1'b1;
        len = LW'(1);
        ready = 8'h01;
        fb = 3'd0;
        check("R1 valid before first edge", int'(gvalid), 0);
        @(negedge clk);
        check("R1 cleared table grants thread 0 valid", int'(gvalid), 1);
        check("R1 cleared table grants thread 0", int'(gtid), 0);

        // Program table with length 0 so the pointer stays at entry 0 (R2).
        len = '0;
        for (int i = 0; i < 10; i++) begin
            wr_en = 1'b1;
            wr_addr = AW'(i);
            wr_tid = PROG[i];
            @(negedge clk);
        end
        wr_en = 1'b0;

        // Vector walk with length 10, pointer starts at entry 0.
        len = LW'(10);
        for (int i = 0; i < NVEC; i++) begin
            ready = VEC[i][15:8];
            fb = VEC[i][7:5];
            @(negedge clk);
            check($sformatf("R4/R5/R6 vector %0d valid", i), int'(gvalid), int'(VEC[i][4]));
            check($sformatf("R4/R5/R6 vector %0d tid", i), int'(gtid), int'(VEC[i][2:0]));
        end

        // R7: share over one full rotation.
        for (int t = 0; t < NT; t++) cnt[t] = 0;
        ready = 8'hFF;
        fb = 3'd0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (gvalid) cnt[gtid]++;
        end
        check("R7 thread 1 share", cnt[1], 5);
        check("R7 thread 2 share", cnt[2], 2);
        check("R7 thread 3 share", cnt[3], 1);
        check("R7 thread 4 share", cnt[4], 1);
        check("R7 thread 5 share", cnt[5], 1);
        check("R7 thread 0 share", cnt[0], 0);

        // R3: shorten length below the current entry.
        len = '0;
        @(negedge clk);
        len = LW'(10);
        repeat (6) @(negedge clk);
        len = LW'(3);
        begin
            int exp_seq [6] = '{1, 1, 2, 1, 1, 2};
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                check($sformatf("R3 shortened rotation step %0d", i), int'(gtid), exp_seq[i]);
            end
        end

        // R8: write to the entry being read in the same cycle.
        len = '0;
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = AW'(0);
        wr_tid = 3'd6;
        @(negedge clk);
        wr_en = 1'b0;
        check("R8 same-cycle read returns old entry", int'(gtid), 1);
        @(negedge clk);
        check("R8 new entry visible next cycle", int'(gtid), 6);
        check("R2 length 0 holds entry 0", int'(gvalid), 1);

        finished = 1'b1;
        finish_run();
    end

endmodule